// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block is the decision engine of a logic analyzer's acquisition path. A term combiner upstream turns each sample of the state bus into a small vector of already-evaluated condition bits. The sequencer walks through a programmed chain of levels. For every valid sample it decides three things: whether the sample goes to trace memory, whether the trigger point has just been reached, and which level handles the next sample.

Each level holds its own program word. The word has an advance condition that moves the sequencer to the following level, and an alternative branch condition with a free target level, which can be the same level, an earlier one or a later one. The word also holds a storage qualifier, a trigger marker and a stop marker. A start pulse opens a run at level 0. The run stays open until a stop-marked level, or the final level, sees its advance condition. Storage after the trigger is obtained by programming one more level after the trigger level, with a permissive qualifier and the stop marker set. Program words are written through a small write port while no run is open. The same words are read back through a combinational read port.

Top module: `trigseq`

## Requirements
- R1: After reset, level_o is 0, running_o, store_en_o and trig_o are low, and every program word reads back as zero.
- R2: A start_i pulse sets level_o to 0 and running_o high in the next cycle, re-arms the trigger, and takes priority over any sample presented in the same cycle.
- R3: A program word has these fields: bits [3:0] advance mask, [7:4] branch mask, [11:8] branch target, [15:12] store mask, [17:16] store mode, [18] trigger marker, [19] stop marker. A condition is met when any cond_i bit selected by its mask is high. A met advance condition in a level other than the last, with the stop marker clear, makes level_o one higher in the next cycle.
- R4: When the branch condition is met and the advance condition is not, the next level is the branch target. The target may be the same level, an earlier level or a later level.
- R5: When the advance and branch conditions are both met, the advance is taken.
- R6: In the last level (11), the branch condition is ignored. A met advance condition ends the run and leaves level_o at 11.
- R7: A met advance condition in a level with the stop marker set ends the run (running_o low in the next cycle) and leaves level_o unchanged.
- R8: store_en_o is high in the cycle after a valid sample taken during a run, according to the mode of the sample's level: 0 never, 1 always, 2 when any store-mask bit of cond_i is high, 3 when none is high.
- R9: trig_o pulses for one cycle after a sample whose advance condition is met in a trigger-marked level. It pulses at most once per run, even if that level is entered again.
- R10: A cycle with sample_vld_i low, or with no run open, leaves level_o unchanged and keeps store_en_o and trig_o low.
- R11: Program writes while running_o is high are ignored. cfg_rdata_o returns the last word accepted for cfg_raddr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a new run at level 0 |
| sample_vld_i | input | 1 | cond_i carries a sample this cycle |
| cond_i | input | 4 | Evaluated condition bits for the sample |
| cfg_we_i | input | 1 | Program word write strobe |
| cfg_waddr_i | input | 4 | Level written |
| cfg_wdata_i | input | 20 | Program word |
| cfg_raddr_i | input | 4 | Level read back |
| cfg_rdata_o | output | 20 | Program word of cfg_raddr_i |
| store_en_o | output | 1 | Store the previous sample |
| trig_o | output | 1 | Trigger pulse |
| level_o | output | 4 | Current level |
| running_o | output | 1 | Run open |

## Verification
A small reference model in the bench is stepped with one condition vector per cycle. Its expected outputs are checked against the design's outputs one cycle later. The main walk drives vectors that meet only the advance mask, only the branch mask, both masks or neither mask. This separates ordered advance from branching to the same, an earlier or a later level, and it exposes the priority rule. The store-mask bits are toggled on their own in the match and miss modes, and the trigger level is entered a second time to show that the pulse does not repeat. Separate passes cover a start pulse that collides with an advancing sample, the ignored branch in the final level, blocked writes during a run, and samples with the valid flag low.

// File: rtl/trigseq_pkg.sv
package trigseq_pkg;
    parameter int SEQ_LEVELS = 12;
    parameter int SEQ_TERMS  = 4;
    localparam int LVL_W     = $clog2(SEQ_LEVELS);

    typedef logic [LVL_W-1:0]     lvl_t;
    typedef logic [SEQ_TERMS-1:0] term_t;

    typedef enum logic [1:0] {
        ST_NEVER  = 2'd0,
        ST_ALWAYS = 2'd1,
        ST_MATCH  = 2'd2,
        ST_MISS   = 2'd3
    } store_mode_e;

    // one program word per level, MSB first
    typedef struct packed {
        logic        halt;
        logic        trig;
        store_mode_e smode;
        term_t       smask;
        lvl_t        etgt;
        term_t       emask;
        term_t       amask;
    } level_cfg_t;

    localparam int   CFG_W    = $bits(level_cfg_t);
    localparam lvl_t LAST_LVL = lvl_t'(SEQ_LEVELS - 1);

    // per-sample decision produced by the evaluator
    typedef struct packed {
        logic adv;
        logic halt_adv;
        logic store;
        logic fire;
        lvl_t next;
    } step_t;

    function automatic logic any_hit(input term_t c, input term_t m);
        return |(c & m);
    endfunction

    function automatic lvl_t clamp_lvl(input lvl_t l);
        return (l > LAST_LVL) ? LAST_LVL : l;
    endfunction
endpackage

// File: rtl/trigseq_prog.sv
module trigseq_prog
    import trigseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             running_i,
    input  logic             cfg_we_i,
    input  lvl_t             cfg_waddr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  lvl_t             cfg_raddr_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  lvl_t             cur_lvl_i,
    output level_cfg_t       cur_cfg_o
);
    logic [SEQ_LEVELS-1:0][CFG_W-1:0] prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= '0;
        end else if (cfg_we_i && !running_i) begin
            for (int i = 0; i < SEQ_LEVELS; i++) begin
                if (cfg_waddr_i == lvl_t'(i)) prog_q[i] <= cfg_wdata_i;
            end
        end
    end

    always_comb begin
        cfg_rdata_o = '0;
        for (int i = 0; i < SEQ_LEVELS; i++) begin
            if (cfg_raddr_i == lvl_t'(i)) cfg_rdata_o = prog_q[i];
        end
    end

    always_comb begin
        cur_cfg_o = '0;
        for (int i = 0; i < SEQ_LEVELS; i++) begin
            if (cur_lvl_i == lvl_t'(i)) cur_cfg_o = level_cfg_t'(prog_q[i]);
        end
    end

    // R11: the program is frozen while a run is open
    p_locked_while_running_r11: assert property (@(posedge clk) disable iff (rst)
        (running_i && cfg_we_i) |=> $stable(prog_q));
endmodule

// File: rtl/trigseq_eval.sv
module trigseq_eval
    import trigseq_pkg::*;
(
    input  level_cfg_t cfg_i,
    input  term_t      cond_i,
    input  lvl_t       cur_lvl_i,
    input  logic       trig_seen_i,
    output step_t      step_o
);
    logic adv, els, is_last, hit_store;

    always_comb begin
        is_last   = (cur_lvl_i == LAST_LVL);
        adv       = any_hit(cond_i, cfg_i.amask);
        els       = !is_last && any_hit(cond_i, cfg_i.emask);
        hit_store = any_hit(cond_i, cfg_i.smask);

        step_o          = '0;
        step_o.adv      = adv;
        step_o.halt_adv = adv && (cfg_i.halt || is_last);
        step_o.fire     = adv && cfg_i.trig && !trig_seen_i;

        unique case (cfg_i.smode)
            ST_NEVER:  step_o.store = 1'b0;
            ST_ALWAYS: step_o.store = 1'b1;
            ST_MATCH:  step_o.store = hit_store;
            ST_MISS:   step_o.store = !hit_store;
            default:   step_o.store = 1'b0;
        endcase

        if (adv) begin
            step_o.next = (cfg_i.halt || is_last) ? cur_lvl_i : lvl_t'(cur_lvl_i + 1'b1);
        end else if (els) begin
            step_o.next = clamp_lvl(cfg_i.etgt);
        end else begin
            step_o.next = cur_lvl_i;
        end
    end
endmodule

// File: rtl/trigseq_core.sv
module trigseq_core
    import trigseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  sample_vld_i,
    input  step_t step_i,
    output lvl_t  lvl_o,
    output logic  running_o,
    output logic  trig_seen_o,
    output logic  store_o,
    output logic  trig_o
);
    lvl_t lvl_q;
    logic running_q, seen_q, store_q, trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q     <= '0;
            running_q <= 1'b0;
            seen_q    <= 1'b0;
            store_q   <= 1'b0;
            trig_q    <= 1'b0;
        end else if (start_i) begin
            lvl_q     <= '0;
            running_q <= 1'b1;
            seen_q    <= 1'b0;
            store_q   <= 1'b0;
            trig_q    <= 1'b0;
        end else if (running_q && sample_vld_i) begin
            lvl_q   <= step_i.next;
            store_q <= step_i.store;
            trig_q  <= step_i.fire;
            seen_q  <= seen_q | step_i.fire;
            if (step_i.halt_adv) running_q <= 1'b0;
        end else begin
            store_q <= 1'b0;
            trig_q  <= 1'b0;
        end
    end

    assign lvl_o       = lvl_q;
    assign running_o   = running_q;
    assign trig_seen_o = seen_q;
    assign store_o     = store_q;
    assign trig_o      = trig_q;

    // R2: start opens a run at level 0 regardless of the sample
    p_start_level0_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (running_q && lvl_q == '0 && !store_q && !trig_q));

    // R3: level never leaves the programmed range
    p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LAST_LVL);

    // R5: an advance that does not stop the run steps exactly one level up
    p_advance_step_r5: assert property (@(posedge clk) disable iff (rst)
        (running_q && sample_vld_i && !start_i && step_i.adv && !step_i.halt_adv)
        |=> (lvl_q == lvl_t'($past(lvl_q) + 1'b1)));

    // R7: a stopping advance closes the run and holds the level
    p_stop_run_r7: assert property (@(posedge clk) disable iff (rst)
        (running_q && sample_vld_i && !start_i && step_i.halt_adv)
        |=> (!running_q && $stable(lvl_q)));

    // R9: a trigger pulse is never issued twice in one run
    p_trig_once_r9: assert property (@(posedge clk) disable iff (rst)
        trig_q |-> !$past(seen_q));

    // R10: no sample, no change
    p_no_sample_r10: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !(running_q && sample_vld_i))
        |=> ($stable(lvl_q) && !store_q && !trig_q));
endmodule

// File: rtl/trigseq.sv
module trigseq
    import trigseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 sample_vld_i,
    input  logic [SEQ_TERMS-1:0] cond_i,
    input  logic                 cfg_we_i,
    input  logic [LVL_W-1:0]     cfg_waddr_i,
    input  logic [CFG_W-1:0]     cfg_wdata_i,
    input  logic [LVL_W-1:0]     cfg_raddr_i,
    output logic [CFG_W-1:0]     cfg_rdata_o,
    output logic                 store_en_o,
    output logic                 trig_o,
    output logic [LVL_W-1:0]     level_o,
    output logic                 running_o
);
    lvl_t       cur_lvl;
    level_cfg_t cur_cfg;
    step_t      step;
    logic       running, trig_seen;

    trigseq_prog u_prog (
        .clk         (clk),
        .rst         (rst),
        .running_i   (running),
        .cfg_we_i    (cfg_we_i),
        .cfg_waddr_i (cfg_waddr_i),
        .cfg_wdata_i (cfg_wdata_i),
        .cfg_raddr_i (cfg_raddr_i),
        .cfg_rdata_o (cfg_rdata_o),
        .cur_lvl_i   (cur_lvl),
        .cur_cfg_o   (cur_cfg)
    );

    trigseq_eval u_eval (
        .cfg_i       (cur_cfg),
        .cond_i      (cond_i),
        .cur_lvl_i   (cur_lvl),
        .trig_seen_i (trig_seen),
        .step_o      (step)
    );

    trigseq_core u_core (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .sample_vld_i (sample_vld_i),
        .step_i       (step),
        .lvl_o        (cur_lvl),
        .running_o    (running),
        .trig_seen_o  (trig_seen),
        .store_o      (store_en_o),
        .trig_o       (trig_o)
    );

    assign level_o   = cur_lvl;
    assign running_o = running;
endmodule

// File: tb/trigseq_tb.sv
`timescale 1ns/1ps
module trigseq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, sample_vld_i = 1'b0;
    logic [3:0]  cond_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [3:0]  cfg_waddr_i = '0, cfg_raddr_i = '0;
    logic [19:0] cfg_wdata_i = '0;
    logic [19:0] cfg_rdata_o;
    logic        store_en_o, trig_o, running_o;
    logic [3:0]  level_o;

    always #2 clk = ~clk;

    trigseq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .sample_vld_i(sample_vld_i),
        .cond_i(cond_i), .cfg_we_i(cfg_we_i), .cfg_waddr_i(cfg_waddr_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_raddr_i(cfg_raddr_i), .cfg_rdata_o(cfg_rdata_o),
        .store_en_o(store_en_o), .trig_o(trig_o), .level_o(level_o), .running_o(running_o)
    );

    typedef struct {
        logic       st;
        logic       tr;
        logic [3:0] lv;
        logic       rn;
        string      tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0, n_fail = 0;
    logic [19:0] m_cfg [12];
    logic [3:0]  m_lvl = '0;
    logic        m_run = 1'b0, m_seen = 1'b0;
    bit          done = 1'b0;

    function automatic logic [19:0] word(input logic halt, input logic trg,
                                         input logic [1:0] sm, input logic [3:0] smask,
                                         input logic [3:0] tgt, input logic [3:0] emask,
                                         input logic [3:0] amask);
        return {halt, trg, sm, smask, tgt, emask, amask};
    endfunction

    // driver: one sample per cycle, model predicts the next outputs
    task automatic cyc(input logic st, input logic vld, input logic [3:0] c, input string tag);
        exp_t e;
        logic [19:0] w;
        logic a, b, h;
        @(negedge clk);
        start_i = st; sample_vld_i = vld; cond_i = c; cfg_we_i = 1'b0;
        e.st = 1'b0; e.tr = 1'b0;
        if (st) begin
            m_lvl = '0; m_run = 1'b1; m_seen = 1'b0;
        end else if (m_run && vld) begin
            w = m_cfg[m_lvl];
            a = |(c & w[3:0]);
            b = (m_lvl != 4'd11) && |(c & w[7:4]);
            h = |(c & w[15:12]);
            e.st = (w[17:16] == 2'd1) || (w[17:16] == 2'd2 && h) || (w[17:16] == 2'd3 && !h);
            if (a) begin
                if (w[18] && !m_seen) begin e.tr = 1'b1; m_seen = 1'b1; end
                if (w[19] || m_lvl == 4'd11) m_run = 1'b0;
                else m_lvl = m_lvl + 4'd1;
            end else if (b) begin
                m_lvl = (w[11:8] > 4'd11) ? 4'd11 : w[11:8];
            end
        end
        e.lv = m_lvl; e.rn = m_run; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [3:0] a, input logic [19:0] d);
        @(negedge clk);
        start_i = 1'b0; sample_vld_i = 1'b0; cond_i = '0;
        cfg_we_i = 1'b1; cfg_waddr_i = a; cfg_wdata_i = d;
        if (!m_run) m_cfg[a] = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        cfg_raddr_i = a;
        #1;
        n_chk++;
        if (cfg_rdata_o !== m_cfg[a]) begin
            n_fail++;
            $display("FAIL %s: readback level %0d got %h expected %h", tag, a, cfg_rdata_o, m_cfg[a]);
        end
    endtask

    // monitor: compare outputs one edge after each sample
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (store_en_o !== e.st || trig_o !== e.tr || level_o !== e.lv || running_o !== e.rn) begin
                    n_fail++;
                    $display("FAIL %s: store/trig/level/run got %b/%b/%0d/%b expected %b/%b/%0d/%b",
                             e.tag, store_en_o, trig_o, level_o, running_o, e.st, e.tr, e.lv, e.rn);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) m_cfg[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        n_chk++;
        if (level_o !== 4'd0 || running_o !== 1'b0 || store_en_o !== 1'b0 || trig_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: level/run/store/trig got %0d/%b/%b/%b expected 0/0/0/0",
                     level_o, running_o, store_en_o, trig_o);
        end
        rd(4'd0, "R1"); rd(4'd11, "R1");

        // program: L0 always, L1 match bit3, L2 trigger miss bit0, L3 post-trigger stop
        wr(4'd0, word(0, 0, 2'd1, 4'b0000, 4'd0, 4'b0010, 4'b0001));
        wr(4'd1, word(0, 0, 2'd2, 4'b1000, 4'd1, 4'b0100, 4'b0010));
        wr(4'd2, word(0, 1, 2'd3, 4'b0001, 4'd0, 4'b1000, 4'b0100));
        wr(4'd3, word(1, 0, 2'd1, 4'b0000, 4'd2, 4'b0010, 4'b1000));
        rd(4'd1, "R11"); rd(4'd2, "R11"); rd(4'd3, "R11");

        cyc(1, 0, 4'b0000, "R2");
        cyc(0, 0, 4'b0001, "R10");        // no valid sample
        cyc(0, 1, 4'b0011, "R5");         // both met, advance wins
        cyc(0, 1, 4'b0100, "R4");         // branch to same level, no store
        cyc(0, 1, 4'b1000, "R8");         // store-mask match
        cyc(0, 1, 4'b0010, "R3");         // advance to L2
        cyc(0, 1, 4'b1000, "R4");         // branch to earlier level
        cyc(0, 1, 4'b0001, "R3");
        cyc(0, 1, 4'b0010, "R3");
        cyc(0, 1, 4'b0100, "R9");         // trigger
        cyc(0, 1, 4'b0000, "R8");         // post-trigger storage
        cyc(0, 1, 4'b0010, "R4");         // back into trigger level
        cyc(0, 1, 4'b0101, "R9");         // advance again, no second pulse, miss store off
        wr(4'd0, word(0, 0, 2'd0, 4'b0000, 4'd0, 4'b0000, 4'b1111));
        rd(4'd0, "R11");                  // write during run ignored
        cyc(0, 1, 4'b1000, "R7");         // stop level ends run
        cyc(0, 1, 4'b1111, "R10");        // idle: no store
        cyc(0, 0, 4'b1111, "R10");

        // start collides with an advancing sample; trigger re-armed
        cyc(1, 0, 4'b0000, "R2");
        cyc(0, 1, 4'b0001, "R3");
        cyc(1, 1, 4'b0010, "R2");
        cyc(0, 1, 4'b0001, "R3");
        cyc(0, 1, 4'b0010, "R3");
        cyc(0, 1, 4'b0100, "R9");
        cyc(0, 1, 4'b1000, "R7");

        // last level and store mode never
        wr(4'd1, word(0, 0, 2'd2, 4'b1000, 4'd10, 4'b0100, 4'b0010));
        wr(4'd10, word(0, 0, 2'd0, 4'b0000, 4'd0, 4'b0000, 4'b0001));
        wr(4'd11, word(0, 0, 2'd1, 4'b0000, 4'd0, 4'b0010, 4'b0001));
        rd(4'd11, "R11");
        cyc(1, 0, 4'b0000, "R2");
        cyc(0, 1, 4'b0001, "R3");
        cyc(0, 1, 4'b0100, "R4");         // later level
        cyc(0, 1, 4'b1111, "R8");         // mode never
        cyc(0, 1, 4'b0010, "R6");         // branch ignored in last level
        cyc(0, 1, 4'b0001, "R6");         // advance in last level ends run
        cyc(0, 1, 4'b0001, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule